// File: doc/BRIEF.md
# Quasi-Resonant Valley Restart Sequencer

This block produces the gate drive of a current-mode flyback running in borderline conduction. It turns the switch on when the synchronized demagnetization comparator falls, which marks core reset, and turns it off when the peak-current comparator trips. A set of clock-cycle timers surrounds that loop. A minimum total period is counted from each turn-on. A blanking window after each turn-off hides leakage ringing. A restart timeout lets the switch restart on its own once the drain ringing has died out. Leading-edge blanking masks the current comparator just after turn-on, and a maximum on-time guard stops pulsing if the current comparator never trips.

A fixed delay after every turn-off, the block samples the plateau overvoltage comparator. If that comparator is high at the sampling instant, a latched overvoltage request is raised and pulsing stops until reset. Two inputs block turn-on. The skip input holds off every restart attempt while it is high. The fault-clear input forces the gate low and also clears the maximum on-time fault.

Analog thresholds and the valley alignment delay are outside this block. Every timer length is a parameter in clock cycles.

Top module: `qr_gate_sequencer`

## Requirements
- R1: While `rst_n` is low, `gate`, `maxon_fault`, `ovp_fault` and `ovp_strobe` are all 0.
- R2: Two gate rising edges are always at least PERIOD_CYC clock edges apart. A demagnetization fall that comes earlier does not turn the gate on, and the gate waits for a later fall or for the timeout.
- R3: A high-to-low transition on `demag_in` that is detected within BLANK_CYC clock edges after turn-off is ignored. It neither turns the gate on nor restarts the timeout.
- R4: When turn-on is otherwise allowed, a high-to-low transition on `demag_in` that is set up before clock edge e turns the gate on at edge e+SYNC_STAGES.
- R5: The restart timeout is reloaded at every turn-off and by every demagnetization fall accepted under R3. If TIMEOUT_CYC clock edges pass with no reload, turn-on becomes allowed without any demagnetization fall.
- R6: `cs_trip` has no effect during the first LEB_CYC clock edges after a turn-on. After that, a high `cs_trip` clears the gate on the next edge.
- R7: While `skip_hold` is 1 the gate does not turn on. After release, the gate turns on at the next demagnetization fall, or at once if the timeout has already expired.
- R8: If the gate stays high for MAXON_CYC clock edges, it is cleared on that edge and `maxon_fault` is set. The fault blocks turn-on until `fault_clr` is asserted, and `fault_clr` also clears it.
- R9: `ovp_strobe` is high for exactly one cycle, beginning OVP_DLY_CYC edges after each turn-off. If `ovp_cmp` is 1 in that cycle, `ovp_fault` sets on the following edge. It then blocks turn-on and is cleared only by `rst_n`. A high `ovp_cmp` at any other time is ignored.
- R10: `fault_clr` takes priority over every turn-on condition. It clears a high gate on the next edge and prevents any turn-on for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| demag_in | input | 1 | Demagnetization comparator output (asynchronous); a fall marks core reset |
| cs_trip | input | 1 | Peak-current comparator output, high when the setpoint is reached |
| skip_hold | input | 1 | Skip-cycle hold; while high, no turn-on is allowed |
| fault_clr | input | 1 | Fault clear, with priority over all turn-on conditions |
| ovp_cmp | input | 1 | Plateau overvoltage comparator output |
| gate | output | 1 | Gate drive of the power switch |
| maxon_fault | output | 1 | Maximum on-time fault flag |
| ovp_strobe | output | 1 | One-cycle plateau sampling strobe |
| ovp_fault | output | 1 | Latched overvoltage request |

## Verification
The hardest case to reach is a demagnetization fall that lands in one particular window. It must either fall inside the post-turn-off blanking while the period clamp has already expired, or fall after blanking but before the period clamp expires. Only in those two windows does a missing blanking or a missing clamp change the gate timing. The stimulus reaches each window by counting the synchronizer latency back from a known turn-off edge. For the blanking case, a long on-time is used first so that the period clamp has expired before turn-off. The timeout reload is then observed through the restart edge it shifts.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

   // Bit width of a countdown that is loaded with len-1.
   function automatic int tmr_width(input int len);
      int w;
      w = $clog2(len);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/qr_down_timer.sv
module qr_down_timer #(
   parameter int LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int W = qr_seq_pkg::tmr_width(LEN);
   localparam logic [W-1:0] LOAD = W'(LEN - 1);

   if (LEN < 1) begin : g_bad_len
      $error("qr_down_timer: LEN must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/qr_demag_edge.sv
module qr_demag_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   logic level;
   logic prev_q;

   if (STAGES == 0) begin : g_direct
      assign level = din;
   end else begin : g_sync
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2+((STAGES>1)?0:1):0], din} ;
      end
      assign level = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign fall = prev_q & ~level;
endmodule

// File: rtl/qr_gate_sequencer.sv
module qr_gate_sequencer #(
   parameter int SYNC_STAGES = 2,
   parameter int PERIOD_CYC  = 16,
   parameter int BLANK_CYC   = 6,
   parameter int TIMEOUT_CYC = 24,
   parameter int LEB_CYC     = 3,
   parameter int MAXON_CYC   = 40,
   parameter int OVP_DLY_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic demag_in,
   input  logic cs_trip,
   input  logic skip_hold,
   input  logic fault_clr,
   input  logic ovp_cmp,
   output logic gate,
   output logic maxon_fault,
   output logic ovp_strobe,
   output logic ovp_fault
);
   localparam int OVP_LEN = OVP_DLY_CYC + 1;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("qr_gate_sequencer: SYNC_STAGES must be 0..4");
   end
   if (LEB_CYC >= MAXON_CYC) begin : g_bad_leb
      $error("qr_gate_sequencer: LEB_CYC must be below MAXON_CYC");
   end

   logic gate_q, maxon_q, ovp_q, ovp_done_q;
   logic demag_fall, valid_fall;
   logic period_ok, blank_ok, tmo_ok, leb_ok, maxon_hit, ovp_done;
   logic turn_on, turn_off;

   qr_demag_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(demag_in), .fall(demag_fall));

   // Timers started at turn-on
   qr_down_timer #(.LEN(PERIOD_CYC)) u_period (
      .clk(clk), .rst_n(rst_n), .start(turn_on), .done(period_ok));
   qr_down_timer #(.LEN(LEB_CYC)) u_leb (
      .clk(clk), .rst_n(rst_n), .start(turn_on), .done(leb_ok));
   qr_down_timer #(.LEN(MAXON_CYC)) u_maxon (
      .clk(clk), .rst_n(rst_n), .start(turn_on), .done(maxon_hit));

   // Timers started at turn-off
   qr_down_timer #(.LEN(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(rst_n), .start(turn_off), .done(blank_ok));
   qr_down_timer #(.LEN(TIMEOUT_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .start(turn_off | valid_fall), .done(tmo_ok));
   qr_down_timer #(.LEN(OVP_LEN)) u_ovp (
      .clk(clk), .rst_n(rst_n), .start(turn_off), .done(ovp_done));

   assign valid_fall = demag_fall & ~gate_q & blank_ok;

   assign turn_off = gate_q & (fault_clr | maxon_hit | (leb_ok & cs_trip));

   assign turn_on  = ~gate_q & ~fault_clr & ~skip_hold & ~maxon_q & ~ovp_q
                   & period_ok & blank_ok & (valid_fall | tmo_ok);

   assign ovp_strobe = ovp_done & ~ovp_done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q     <= 1'b0;
         maxon_q    <= 1'b0;
         ovp_q      <= 1'b0;
         ovp_done_q <= 1'b1;
      end else begin
         ovp_done_q <= ovp_done;
         if (turn_on)       gate_q <= 1'b1;
         else if (turn_off) gate_q <= 1'b0;
         if (fault_clr)                 maxon_q <= 1'b0;
         else if (gate_q && maxon_hit)  maxon_q <= 1'b1;
         if (ovp_strobe && ovp_cmp)     ovp_q <= 1'b1;
      end
   end

   assign gate        = gate_q;
   assign maxon_fault = maxon_q;
   assign ovp_fault   = ovp_q;
endmodule

// File: rtl/qr_gate_sequencer_chk.sv
module qr_gate_sequencer_chk #(
   parameter int PERIOD_CYC = 16,
   parameter int LEB_CYC    = 3,
   parameter int MAXON_CYC  = 40
) (
   input logic clk,
   input logic rst_n,
   input logic fault_clr,
   input logic skip_hold,
   input logic gate,
   input logic maxon_fault,
   input logic ovp_strobe,
   input logic ovp_fault
);
   logic gate_d;
   int   gap_q;
   int   on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_d <= 1'b0;
         gap_q  <= PERIOD_CYC;
         on_q   <= 0;
      end else begin
         gate_d <= gate;
         if (gate && !gate_d)       gap_q <= 1;
         else if (gap_q < PERIOD_CYC) gap_q <= gap_q + 1;
         if (!gate)                 on_q <= 0;
         else if (on_q < MAXON_CYC) on_q <= on_q + 1;
      end
   end

   // R2: rise-to-rise spacing
   a_r2_period_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && !gate_d) |-> gap_q >= PERIOD_CYC);

   // R6: minimum on-time unless forced off
   a_r6_leb_min_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && gate_d && !$past(fault_clr)) |-> on_q >= LEB_CYC);

   // R8: on-time bounded
   a_r8_maxon_bound: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> on_q < MAXON_CYC);

   a_r8_fault_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(maxon_fault) |-> !gate);

   // R10: fault clear forces gate low
   a_r10_clear_priority: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |=> !gate);

   // R7: skip hold blocks turn-on
   a_r7_skip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_hold && !gate) |=> !gate);

   // R9: latched overvoltage, set only by the strobe
   a_r9_ovp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_fault |=> ovp_fault);

   a_r9_ovp_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovp_fault) |-> $past(ovp_strobe));
endmodule

bind qr_gate_sequencer qr_gate_sequencer_chk #(
   .PERIOD_CYC(PERIOD_CYC), .LEB_CYC(LEB_CYC), .MAXON_CYC(MAXON_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fault_clr(fault_clr), .skip_hold(skip_hold),
   .gate(gate), .maxon_fault(maxon_fault), .ovp_strobe(ovp_strobe),
   .ovp_fault(ovp_fault)
);

// File: tb/test_qr_gate_sequencer.sv
module test_qr_gate_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int K_RISE = 0, K_FALL = 1, K_STROBE = 2;

   typedef struct {
      int    cyc;
      int    kind;
      string req;
   } ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic demag_in = 1'b1, cs_trip = 1'b0, skip_hold = 1'b1;
   logic fault_clr = 1'b0, ovp_cmp = 1'b0;
   logic gate, maxon_fault, ovp_strobe, ovp_fault;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;
   ev_t exp_q[$];
   logic gate_prev = 1'b0;

   qr_gate_sequencer i_qr_gate_sequencer (
      .clk(clk), .rst_n(rst_n), .demag_in(demag_in), .cs_trip(cs_trip),
      .skip_hold(skip_hold), .fault_clr(fault_clr), .ovp_cmp(ovp_cmp),
      .gate(gate), .maxon_fault(maxon_fault), .ovp_strobe(ovp_strobe),
      .ovp_fault(ovp_fault));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic push(input int c, input int k, input string req);
      ev_t e;
      e.cyc = c; e.kind = k; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic score(input int k);
      ev_t e;
      if (exp_q.size() == 0) begin
         n_chk++; n_fail++;
         $display("FAIL R4 unexpected event actual=kind%0d@%0d expected=none", k, cyc);
      end else begin
         e = exp_q.pop_front();
         check({e.req, " event kind"}, k, e.kind);
         check({e.req, " event cycle"}, cyc, e.cyc);
      end
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (gate != gate_prev) score(gate ? K_RISE : K_FALL);
         if (ovp_strobe) score(K_STROBE);
      end
      gate_prev <= gate;
   end

   task automatic to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   initial begin
      to(2);
      check("R1 gate", gate, 0);
      check("R1 maxon_fault", maxon_fault, 0);
      check("R1 ovp_fault", ovp_fault, 0);
      check("R1 ovp_strobe", ovp_strobe, 0);
      to(4);  rst_n = 1'b1;
      to(5);  demag_in = 1'b0;          // fall while skip held (R7)
      to(8);  demag_in = 1'b1;
      to(10); skip_hold = 1'b0;
      to(12); check("R7 no start while timeout running", gate, 0);
      push(15, K_RISE, "R7_R4");
      demag_in = 1'b0;
      to(15); cs_trip = 1'b1;           // LEB masks the trip (R6)
      push(18, K_FALL, "R6");
      push(26, K_STROBE, "R9");
      to(18); cs_trip = 1'b0; demag_in = 1'b1;
      to(20); demag_in = 1'b0;          // inside blanking
      to(22); demag_in = 1'b1;
      to(24); demag_in = 1'b0;          // after blanking, before period (R2)
      to(27); demag_in = 1'b1;
      to(30); demag_in = 1'b0;          // after period
      push(33, K_RISE, "R2");
      to(53); cs_trip = 1'b1;
      push(54, K_FALL, "R6");
      push(62, K_STROBE, "R9");
      to(54); cs_trip = 1'b0; demag_in = 1'b1;
      to(55); demag_in = 1'b0;          // inside blanking, period expired (R3)
      push(78, K_RISE, "R3_R5");
      push(118, K_FALL, "R8");
      push(126, K_STROBE, "R9");
      to(117); check("R8 fault not yet", maxon_fault, 0);
      to(118); check("R8 fault set", maxon_fault, 1);
      to(150); check("R8 no restart while fault", gate, 0);
      fault_clr = 1'b1;
      to(151); fault_clr = 1'b0;
      check("R8 fault cleared", maxon_fault, 0);
      push(152, K_RISE, "R8_R5");
      push(157, K_FALL, "R10");
      push(165, K_STROBE, "R9");
      to(156); fault_clr = 1'b1;
      to(160); demag_in = 1'b1;
      to(170); demag_in = 1'b0;         // valid fall reloads timeout
      to(185); check("R10 held clear blocks start", gate, 0);
      to(190); fault_clr = 1'b0;
      push(197, K_RISE, "R10_R5");
      to(200); cs_trip = 1'b1;
      push(201, K_FALL, "R6");
      push(209, K_STROBE, "R9");
      to(201); cs_trip = 1'b0;
      to(202); ovp_cmp = 1'b1;
      to(204); ovp_cmp = 1'b0;
      to(206); check("R9 ovp off-strobe ignored", ovp_fault, 0);
      to(208); ovp_cmp = 1'b1;
      to(209); check("R9 ovp before latch", ovp_fault, 0);
      to(210); check("R9 ovp latched", ovp_fault, 1);
      to(212); ovp_cmp = 1'b0;
      to(230); fault_clr = 1'b1;
      to(231); fault_clr = 1'b0;
      to(240);
      check("R9 ovp survives fault clear", ovp_fault, 1);
      check("R9 no restart after ovp", gate, 0);
      check("R4 all expected events seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule